// File: doc/BRIEF.md
# Strap-Addressed Single-Byte I2C Target

This block is an I2C target for standard-mode (100 kHz) buses. A fast system clock oversamples the open-drain SCL and SDA lines. The block pulls SDA low through a single enable output and never drives SCL. It answers one 7-bit address. The upper four bits of that address are fixed at `1001`. The lower three bits come from two three-level strap inputs, and each strap arrives already encoded as a 2-bit code. The master generates every SCL pulse.

Each transfer carries exactly one data byte and has no register pointer. In a write, the byte sent by the master lands in an output register, and a one-cycle strobe marks the update. In a read, the target returns a snapshot of a status input taken when the address is acknowledged. The straps are evaluated at every address byte, so changing them while the system runs moves the target to a new address from the next transfer onward.

Top module: `i2c_strap_target`

## Requirements
- R1: Strap codes are 2'b00 = low (0), 2'b01 = mid (1) and 2'b10 = high (2); 2'b11 counts as high. With index = 3·(strap A) + (strap B), capped at 7, the target address is {1001, index[2:0]}. This spans 0x48 (low/low) to 0x4F.
- R2: Strap pairs high/mid and high/high both select 0x4F, and with high/mid an address of 0x4E is not answered.
- R3: The straps are evaluated at each address byte. A change between transfers takes effect on the next address, and a change during the data byte does not disturb the transfer in progress.
- R4: For an address byte whose upper seven bits match, the target holds SDA low through the ninth SCL pulse (ACK). Bit 0 of the address byte selects write (0) or read (1).
- R5: In a write, the target shifts in the data byte MSB first and ACKs it. On the eighth data rising edge it loads the byte into `wr_data_o` and raises `wr_stb_o` for exactly one cycle. `wr_data_o` changes at no other time and resets to 0.
- R6: In a read, `status_i` is captured when the address is matched. The captured byte is driven MSB first on the eight SCL pulses after the ACK, and later changes of `status_i` have no effect on it.
- R7: For a non-matching address, the target does not ACK, drives nothing and strobes nothing until the next START.
- R8: A START (SDA falls while SCL is high) restarts address reception from any state. A STOP (SDA rises while SCL is high) returns the target to idle from any state, including partway through an address.
- R9: `sda_oe_o` changes only while SCL is low, never while SCL is high.
- R10: After the last read bit, the target releases SDA for the master's acknowledge bit and drives nothing more in that transfer.
- R11: Only one data byte is accepted per transfer. A second write byte is not ACKed and does not change `wr_data_o` or pulse `wr_stb_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| strap_a_i | input | 2 | First strap code (weight 3) |
| strap_b_i | input | 2 | Second strap code (weight 1) |
| status_i | input | 8 | Byte returned on a read |
| wr_data_o | output | 8 | Last byte written by the master |
| wr_stb_o | output | 1 | One-cycle pulse when `wr_data_o` is loaded |

## Verification
Every result is due three system clocks after the SCL edge that causes it at the pins. Two cycles of that delay come from the input synchronizer, and the third is the state register.

The bench drives lines on falling clock edges. Each SCL fall schedules the expected SDA enable for three cycles later, and each eighth data rise schedules the strobe and data update for three cycles later. A per-cycle model then compares all three outputs on every clock, just after the rising edge. Acknowledge and read bits are additionally sampled on the wired-AND line in the middle of SCL high, well after the enable has settled.

// File: rtl/i2c_strap_pkg.sv
package i2c_strap_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        tgt_state_e             st;
        logic [BYTE_W-1:0]      sh;
        logic [BIT_CNT_W-1:0]   cnt;
        logic                   rw;
        logic                   oe;
        logic [BYTE_W-1:0]      wdat;
        logic                   stb;
    } tgt_regs_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int   STAGES = 2,
    parameter logic IDLE_V = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic sync_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain_d, chain_q;
    logic              prev_d, prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb chain_d = line_i;
        end else begin : g_multi
            always_comb chain_d = {chain_q[STAGES-2:0], line_i};
        end
    endgenerate

    always_comb prev_d = chain_q[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{IDLE_V}};
            prev_q  <= IDLE_V;
        end else begin
            chain_q <= chain_d;
            prev_q  <= prev_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/i2c_strap_addr.sv
module i2c_strap_addr #(
    parameter logic [3:0] ADDR_HI = 4'b1001
) (
    input  logic [1:0] strap_a_i,
    input  logic [1:0] strap_b_i,
    output logic [6:0] addr_o
);
    function automatic logic [3:0] level(input logic [1:0] code);
        case (code)
            2'b00:   level = 4'd0;
            2'b01:   level = 4'd1;
            default: level = 4'd2;
        endcase
    endfunction

    logic [3:0] idx_sum;
    logic [2:0] idx_low;

    always_comb begin
        idx_sum = 4'd3 * level(strap_a_i) + level(strap_b_i);
        idx_low = (idx_sum > 4'd7) ? 3'd7 : idx_sum[2:0];
        addr_o  = {ADDR_HI, idx_low};
    end
endmodule

// File: rtl/i2c_strap_target.sv
module i2c_strap_target
    import i2c_strap_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] ADDR_HI     = 4'b1001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        strap_a_i,
    input  logic [1:0]        strap_b_i,
    input  logic [BYTE_W-1:0] status_i,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              wr_stb_o
);
    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic scl_s, scl_p, sda_s, sda_p;
    logic scl_rise, scl_fall, bus_start, bus_stop;
    logic [6:0] my_addr;
    logic [BYTE_W-1:0] byte_in;
    tgt_regs_t q, d;

    i2c_line_sync #(.STAGES(SYNC_STAGES), .IDLE_V(1'b1)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .sync_o(scl_s), .prev_o(scl_p)
    );

    i2c_line_sync #(.STAGES(SYNC_STAGES), .IDLE_V(1'b1)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .sync_o(sda_s), .prev_o(sda_p)
    );

    i2c_strap_addr #(.ADDR_HI(ADDR_HI)) u_addr (
        .strap_a_i(strap_a_i), .strap_b_i(strap_b_i), .addr_o(my_addr)
    );

    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        bus_start = scl_s & scl_p & sda_p & ~sda_s;
        bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
        byte_in   = {q.sh[BYTE_W-2:0], sda_s};
    end

    always_comb begin
        d     = q;
        d.stb = 1'b0;
        if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (bus_start) begin
            d.st  = ST_ADDR;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR: if (scl_rise) begin
                    d.sh  = byte_in;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) begin
                        if (byte_in[7:1] == my_addr) begin
                            d.st = ST_ADDR_ACK;
                            d.rw = byte_in[0];
                            if (byte_in[0]) d.sh = status_i;
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    if (!q.oe) begin
                        d.oe = 1'b1;
                    end else begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st = ST_RDATA;
                            d.oe = ~q.sh[BYTE_W-1];
                        end else begin
                            d.st = ST_WDATA;
                            d.oe = 1'b0;
                        end
                    end
                end
                ST_WDATA: if (scl_rise) begin
                    d.sh  = byte_in;
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == LAST_BIT) begin
                        d.wdat = byte_in;
                        d.stb  = 1'b1;
                        d.st   = ST_WDATA_ACK;
                    end
                end
                ST_WDATA_ACK: if (scl_fall) begin
                    if (!q.oe) begin
                        d.oe = 1'b1;
                    end else begin
                        d.oe = 1'b0;
                        d.st = ST_IGNORE;
                    end
                end
                ST_RDATA: if (scl_fall) begin
                    if (q.cnt == LAST_BIT) begin
                        d.oe = 1'b0;
                        d.st = ST_IGNORE;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                        d.sh  = {q.sh[BYTE_W-2:0], 1'b0};
                        d.oe  = ~q.sh[BYTE_W-2];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, sh: '0, cnt: '0, rw: 1'b0, oe: 1'b0, wdat: '0, stb: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o  = q.oe;
    assign wr_data_o = q.wdat;
    assign wr_stb_o  = q.stb;

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe_o != $past(sda_oe_o)) |-> (!$past(scl_s) || $past(bus_start) || $past(bus_stop))); // R9
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_o |=> !wr_stb_o); // R5
    AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_o != $past(wr_data_o)) |-> wr_stb_o); // R5
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IGNORE) |-> (!sda_oe_o && !wr_stb_o)); // R7
endmodule

// File: tb/i2c_strap_target_tb.sv
module i2c_strap_target_tb;
    localparam int HALF = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic [1:0] sa = 2'b00, sb = 2'b00;
    logic [7:0] status = 8'h00;
    logic       sda_oe, wr_stb;
    logic [7:0] wr_data;
    wire        sda_line = sda_m & ~sda_oe;

    i2c_strap_target u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
        .strap_a_i(sa), .strap_b_i(sb), .status_i(status),
        .wr_data_o(wr_data), .wr_stb_o(wr_stb)
    );

    int checks = 0, errors = 0, mc = 0;
    bit mon_on = 0;
    int oe_due[$];
    bit oe_val[$];
    int stb_due[$];
    logic [7:0] stb_dat[$];
    bit exp_oe = 0, exp_stb = 0;
    logic [7:0] exp_data = 8'h00;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-cycle reference model, sampled just after each rising edge
    always @(posedge clk) begin
        #2;
        if (mon_on) begin
            mc++;
            while (oe_due.size() > 0 && oe_due[0] <= mc) begin
                exp_oe = oe_val[0];
                void'(oe_due.pop_front());
                void'(oe_val.pop_front());
            end
            exp_stb = 0;
            if (stb_due.size() > 0 && stb_due[0] == mc) begin
                exp_stb  = 1;
                exp_data = stb_dat[0];
                void'(stb_due.pop_front());
                void'(stb_dat.pop_front());
            end
            check("R4 R9 sda_oe per cycle", sda_oe, exp_oe);
            check("R5 R11 wr_stb per cycle", wr_stb, exp_stb);
            check("R5 R11 wr_data per cycle", wr_data, exp_data);
        end
    end

    function automatic logic [6:0] addr_of(logic [1:0] a, logic [1:0] b);
        logic [3:0] la, lb, idx;
        la  = (a == 2'b00) ? 4'd0 : (a == 2'b01) ? 4'd1 : 4'd2;
        lb  = (b == 2'b00) ? 4'd0 : (b == 2'b01) ? 4'd1 : 4'd2;
        idx = 4'd3 * la + lb;
        if (idx > 4'd7) idx = 4'd7;
        return {4'b1001, idx[2:0]};
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic scl_up(bit stb, logic [7:0] dv);
        @(negedge clk);
        scl_m = 1'b1;
        if (stb) begin
            stb_due.push_back(mc + 3);
            stb_dat.push_back(dv);
        end
    endtask

    task automatic scl_down(bit e);
        @(negedge clk);
        scl_m = 1'b0;
        oe_due.push_back(mc + 3);
        oe_val.push_back(e);
    endtask

    task automatic clock_bit(bit b, bit stb, logic [7:0] dv, bit e_after, output bit seen);
        tick(HALF / 2);
        sda_m = b;
        tick(HALF / 2 - 1);
        scl_up(stb, dv);
        tick(HALF / 2);
        seen = sda_line;
        tick(HALF / 2 - 1);
        scl_down(e_after);
    endtask

    task automatic start_cond();
        tick(HALF / 2);
        sda_m = 1'b1;
        tick(HALF / 2);
        scl_up(0, 8'h00);
        tick(HALF / 2);
        sda_m = 1'b0;
        tick(HALF / 2);
        scl_down(0);
    endtask

    task automatic stop_cond();
        tick(HALF / 2);
        sda_m = 1'b0;
        tick(HALF / 2);
        scl_up(0, 8'h00);
        tick(HALF / 2);
        sda_m = 1'b1;
        tick(HALF);
    endtask

    task automatic send_addr(string tag, logic [6:0] a, bit rw, bit match, logic [7:0] st_now);
        logic [7:0] b;
        bit s;
        b = {a, rw};
        for (int i = 7; i >= 1; i--) clock_bit(b[i], 0, 8'h00, 0, s);
        clock_bit(b[0], 0, 8'h00, match, s);
        clock_bit(1'b1, 0, 8'h00, (match && rw) ? ~st_now[7] : 1'b0, s);
        check(tag, s, match ? 1'b0 : 1'b1);
    endtask

    task automatic send_wbyte(logic [7:0] dv, bit accept);
        bit s;
        for (int i = 7; i >= 1; i--) clock_bit(dv[i], 0, 8'h00, 0, s);
        clock_bit(dv[0], accept, dv, accept, s);
        clock_bit(1'b1, 0, 8'h00, 0, s);
        if (accept) check("R5 data byte ACK", s, 1'b0);
        else        check("R11 extra byte NACK", s, 1'b1);
    endtask

    task automatic recv_rbyte(string tag, logic [7:0] st);
        logic [7:0] got;
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, 0, 8'h00, (i > 0) ? ~st[i-1] : 1'b0, s);
            got[i] = s;
        end
        check(tag, got, st);
        clock_bit(1'b1, 0, 8'h00, 0, s);
        check("R10 line released on master NACK", s, 1'b1);
    endtask

    task automatic write_xfer(string tag, logic [7:0] dv);
        start_cond();
        send_addr(tag, addr_of(sa, sb), 1'b0, 1'b1, 8'h00);
        send_wbyte(dv, 1'b1);
        stop_cond();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        bit s;
        tick(5);
        check("R5 reset wr_data", wr_data, 8'h00);
        check("R5 reset wr_stb", wr_stb, 1'b0);
        check("R9 reset sda_oe", sda_oe, 1'b0);
        rst_n = 1'b1;
        tick(3);
        mon_on = 1;
        tick(5);

        // R1: every strap pair, including the 2'b11 code treated as high
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                sa = a[1:0];
                sb = b[1:0];
                write_xfer("R1 strap address ACK", 8'hA0 + 8'(a * 3 + b));
            end
        end
        sa = 2'b11; sb = 2'b11;
        write_xfer("R1 code 11 as high", 8'hC3);

        // R2: high/mid folds to 0x4F, 0x4E not answered
        sa = 2'b10; sb = 2'b01;
        write_xfer("R2 high/mid answers 0x4F", 8'h4F);
        start_cond();
        send_addr("R2 0x4E ignored under high/mid", 7'h4E, 1'b0, 1'b0, 8'h00);
        send_wbyte(8'hEE, 1'b0);
        stop_cond();

        // R3: straps changed between transfers and during a data byte
        sa = 2'b00; sb = 2'b00;
        write_xfer("R3 0x48 before change", 8'h12);
        sa = 2'b01; sb = 2'b01;
        start_cond();
        send_addr("R3 old address dropped", 7'h48, 1'b0, 1'b0, 8'h00);
        stop_cond();
        start_cond();
        send_addr("R3 new address 0x4C", 7'h4C, 1'b0, 1'b1, 8'h00);
        sa = 2'b00;
        send_wbyte(8'h34, 1'b1);
        stop_cond();
        sa = 2'b01;

        // R6: read snapshot, status changed after the match
        status = 8'h5A;
        start_cond();
        send_addr("R4 read address ACK", addr_of(sa, sb), 1'b1, 1'b1, 8'h5A);
        status = 8'hFF;
        recv_rbyte("R6 read byte snapshot", 8'h5A);
        stop_cond();
        status = 8'h81;
        start_cond();
        send_addr("R4 read address ACK", addr_of(sa, sb), 1'b1, 1'b1, 8'h81);
        status = 8'h00;
        recv_rbyte("R6 read byte 0x81", 8'h81);
        stop_cond();

        // R7: wrong address read leaves the bus alone
        status = 8'h00;
        start_cond();
        send_addr("R7 wrong address NACK", 7'h30, 1'b1, 1'b0, 8'h00);
        recv_rbyte("R7 nothing driven", 8'hFF);
        stop_cond();

        // R8: repeated START after a mismatch, STOP inside an address
        start_cond();
        send_addr("R8 mismatch before restart", 7'h11, 1'b0, 1'b0, 8'h00);
        start_cond();
        send_addr("R8 repeated START address ACK", addr_of(sa, sb), 1'b0, 1'b1, 8'h00);
        send_wbyte(8'h3C, 1'b1);
        stop_cond();
        start_cond();
        for (int i = 0; i < 3; i++) clock_bit(1'b1, 0, 8'h00, 0, s);
        stop_cond();
        write_xfer("R8 after STOP in address", 8'h5C);
        status = 8'h96;
        start_cond();
        send_addr("R8 write then restart", addr_of(sa, sb), 1'b0, 1'b1, 8'h00);
        send_wbyte(8'h69, 1'b1);
        start_cond();
        send_addr("R8 restart into read", addr_of(sa, sb), 1'b1, 1'b1, 8'h96);
        recv_rbyte("R8 read after restart", 8'h96);
        stop_cond();

        // R11: second data byte rejected
        start_cond();
        send_addr("R11 address ACK", addr_of(sa, sb), 1'b0, 1'b1, 8'h00);
        send_wbyte(8'h11, 1'b1);
        send_wbyte(8'h22, 1'b0);
        stop_cond();
        tick(10);
        check("R11 wr_data keeps first byte", wr_data, 8'h11);

        summary();
    end
endmodule